// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake-Up

This block is an asynchronous serial port for a shared multidrop line. It receives frames on an oversampled input, decides each bit by a three-sample vote near the bit centre, and moves each finished frame into a receive holding register. It reports four conditions: receive full, framing error, overrun, and the frame's multiprocessor flag. In multiprocessor format every frame carries one extra bit after the eight data bits. That bit marks the frame as an address (1) or as data (0).

A wake-up control bit lets a listening node sleep through traffic meant for other nodes. While it is set, data frames disappear without trace. The first address frame clears the bit in hardware and is received as usual, so software can then compare the address.

A small transmitter shares the bit timing. It has a transmit-empty flag, a transmit-end flag and a transmit-end interrupt. The transmit-end flag is cleared by a two-step read-then-write handshake on the transmit-empty flag. Software uses a four-location register port: control at 0, status at 1, received data at 2, transmit data at 3.

Top module: `mdrop_uart`

## Requirements
- R1: The receiver takes a frame made of one low start bit, eight data bits least significant first, then (only when control bit 0, multiprocessor format, is 1) one multiprocessor bit, then one stop bit, each bit lasting OVS clock ticks (16 by default). When the frame is accepted and status bit 0 (receive full) is clear, the data is placed in the received-data register and receive full is set. Status bit 3 takes the frame's multiprocessor bit (0 outside multiprocessor format).
- R2: Each bit is decided by a majority of three consecutive samples at the bit centre, so a one-tick glitch does not change the result. A start bit that has returned high by its centre is discarded with no frame and no flag.
- R3: A stop bit sampled low sets status bit 1 (framing error); the data is still transferred. Writing status with bit 1 at 0 clears it; writing 1 there leaves it.
- R4: A frame accepted while receive full is set, and not read in the same cycle, sets status bit 2 (overrun) and leaves the received-data register unchanged. Writing status with bit 2 at 0 clears it.
- R5: Reading address 2 clears receive full. irq_rx equals receive full AND control bit 2. irq_rxerr equals (framing error OR overrun) AND control bit 3.
- R6: With multiprocessor format and control bit 1 (wake-up) both set, a frame whose multiprocessor bit is 0 causes no transfer, no error check and no flag change. Receive full, framing error, overrun, status bit 3 and the received-data register keep their values.
- R7: With multiprocessor format and wake-up set, a frame whose multiprocessor bit is 1 clears control bit 1 in hardware, sets status bit 3 and is received normally. Later data frames are then received.
- R8: When multiprocessor format is 0, the wake-up bit has no effect: frames are received and control bit 1 keeps its written value.
- R9: irq_txend is high exactly when status bit 5 (transmit end) and control bit 4 (transmit-end interrupt enable) are both 1. Clearing control bit 4 withdraws it.
- R10: Reading status while bit 4 (transmit empty) is 1 arms a clear. A following status write with bit 4 at 0 then clears both transmit empty and transmit end, and starts transmission of address 3. The same write without the prior read changes neither flag. Out of reset both flags are 1.
- R11: The transmitter sends on txd, least significant first: a start bit, the eight data bits of address 3, control bit 5 as the multiprocessor bit (only in multiprocessor format), and a stop bit, each bit OVS ticks long. When the stop bit ends with transmit empty still 1, transmit end is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 received data, 3 transmit data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_rxerr | output | 1 | Receive-error interrupt request |
| irq_txend | output | 1 | Transmit-end interrupt request |

## Verification
Two kinds of internal fault show at the ports. A wrong bit counter or a misplaced sample point corrupts the received byte. It also swaps the multiprocessor bit into the data, or the reverse, and this is visible in the status and data reads right after each frame. A wake-up latch that fails to suppress or fails to clear shows within one frame time, as a receive-full or interrupt that should not be there or is missing. A handshake flaw in the transmit-empty arming shows at the next status read, as a transmit-end flag that changed when it should not. A stuck transmit shifter shows as a wrong bit on txd within one bit period.

// File: rtl/mdrop_uart_pkg.sv
package mdrop_uart_pkg;
  localparam int DATA_W  = 8;
  localparam int SHIFT_W = DATA_W + 1;
  localparam int FRAME_W = DATA_W + 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RXD  = 2'd2;
  localparam logic [1:0] A_TXD  = 2'd3;

  localparam int C_MPFMT = 0;
  localparam int C_WAKE  = 1;
  localparam int C_RIE   = 2;
  localparam int C_EIE   = 3;
  localparam int C_TEIE  = 4;
  localparam int C_TXMPB = 5;

  localparam int S_RFULL = 0;
  localparam int S_FERR  = 1;
  localparam int S_OVR   = 2;
  localparam int S_MPB   = 3;
  localparam int S_TDE   = 4;
  localparam int S_TEND  = 5;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_SHIFT, RX_STOP} rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              mpb;
    logic              stop_ok;
  } rx_frame_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic int unsigned payload_bits(input logic mp);
    return mp ? DATA_W + 1 : DATA_W;
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input logic [SHIFT_W-1:0] sr, input logic mp);
    return mp ? sr[DATA_W-1:0] : sr[SHIFT_W-1:1];
  endfunction

  function automatic logic [FRAME_W-1:0] tx_frame(input logic [DATA_W-1:0] d, input logic mpb,
                                                  input logic mp);
    return mp ? {1'b1, mpb, d, 1'b0} : {2'b11, d, 1'b0};
  endfunction
endpackage

// File: rtl/mdrop_uart_tick.sv
module mdrop_uart_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LIM = CW'(DIV > 1 ? DIV - 1 : 0);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LIM) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LIM);
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrop_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      mp_fmt,
  output logic      frame_done,
  output rx_frame_t frame,
  output logic      false_start
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] SMP_A = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SMP_B = CW'(OVS / 2);
  localparam logic [CW-1:0] SMP_C = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OVS - 1);

  logic [1:0]         sync_q;
  logic               rx_s;
  rx_state_e          state_q;
  logic [CW-1:0]      cnt_q;
  logic               smp_a_q, smp_b_q;
  logic [SHIFT_W-1:0] sr_q;
  logic [3:0]         pos_q;
  logic               bit_val;

  assign rx_s    = sync_q[1];
  assign bit_val = vote3(smp_a_q, smp_b_q, rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      smp_a_q     <= 1'b1;
      smp_b_q     <= 1'b1;
      sr_q        <= '0;
      pos_q       <= '0;
      frame_done  <= 1'b0;
      frame       <= '0;
      false_start <= 1'b0;
    end else begin
      frame_done  <= 1'b0;
      false_start <= 1'b0;
      if (tick) begin
        if (state_q == RX_IDLE) begin
          if (!rx_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == SMP_A) smp_a_q <= rx_s;
          if (cnt_q == SMP_B) smp_b_q <= rx_s;
          if (cnt_q == SMP_C) begin
            case (state_q)
              RX_START: if (bit_val) begin
                state_q     <= RX_IDLE;
                false_start <= 1'b1;
              end
              RX_SHIFT: begin
                sr_q  <= {bit_val, sr_q[SHIFT_W-1:1]};
                pos_q <= pos_q + 1'b1;
              end
              RX_STOP: begin
                frame_done    <= 1'b1;
                frame.data    <= frame_data(sr_q, mp_fmt);
                frame.mpb     <= mp_fmt & sr_q[SHIFT_W-1];
                frame.stop_ok <= bit_val;
                state_q       <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt_q == LAST) begin
            if (state_q == RX_START) begin
              state_q <= RX_SHIFT;
              pos_q   <= '0;
            end else if (state_q == RX_SHIFT && pos_q == 4'(payload_bits(mp_fmt))) begin
              state_q <= RX_STOP;
            end
          end
        end
      end
    end
  end

  // R2
  false_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |-> (state_q == RX_IDLE && !frame_done));
endmodule

// File: rtl/mdrop_uart_tx.sv
module mdrop_uart_tx
  import mdrop_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] data,
  input  logic              mpb,
  input  logic              mp_fmt,
  output logic              load,
  output logic              done,
  output logic              txd
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q;
  logic [3:0]         left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
      load   <= 1'b0;
      done   <= 1'b0;
    end else begin
      load <= 1'b0;
      done <= 1'b0;
      if (!busy_q) begin
        if (pending) begin
          busy_q <= 1'b1;
          sh_q   <= tx_frame(data, mpb, mp_fmt);
          left_q <= 4'(payload_bits(mp_fmt) + 2);
          cnt_q  <= '0;
          load   <= 1'b1;
        end
      end else if (tick) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
          if (left_q == 4'd1) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd = busy_q ? sh_q[0] : 1'b1;

  // R11
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !txd);
endmodule

// File: rtl/mdrop_uart_regs.sv
module mdrop_uart_regs
  import mdrop_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              frame_done,
  input  rx_frame_t         frame,
  input  logic              tx_load,
  input  logic              tx_done,
  output logic              mp_fmt,
  output logic              tx_mpb,
  output logic              tx_pending,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq_rx,
  output logic              irq_rxerr,
  output logic              irq_txend
);
  logic mp_q, wake_q, rie_q, eie_q, teie_q, txmpb_q;
  logic rfull_q, ferr_q, ovr_q, mpb_q, tde_q, tend_q, arm_q;
  logic [DATA_W-1:0] rdr_q, tdr_q;

  logic wr_ctrl, wr_stat, wr_tdr, rd_stat, rd_rx;
  logic suppressed, accepted, wake_hit, overrun_ev, tde_clear, tend_set;

  assign wr_ctrl = wr && addr == A_CTRL;
  assign wr_stat = wr && addr == A_STAT;
  assign wr_tdr  = wr && addr == A_TXD;
  assign rd_stat = rd && addr == A_STAT;
  assign rd_rx   = rd && addr == A_RXD;

  assign suppressed = frame_done & mp_q & wake_q & ~frame.mpb;
  assign accepted   = frame_done & ~suppressed;
  assign wake_hit   = accepted & mp_q & wake_q;
  assign overrun_ev = accepted & rfull_q & ~rd_rx;
  assign tde_clear  = wr_stat & ~wdata[S_TDE] & arm_q & tde_q;
  assign tend_set   = tx_done & tde_q & ~tde_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp_q <= 1'b0; wake_q <= 1'b0; rie_q <= 1'b0;
      eie_q <= 1'b0; teie_q <= 1'b0; txmpb_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mp_q    <= wdata[C_MPFMT];
        wake_q  <= wdata[C_WAKE];
        rie_q   <= wdata[C_RIE];
        eie_q   <= wdata[C_EIE];
        teie_q  <= wdata[C_TEIE];
        txmpb_q <= wdata[C_TXMPB];
      end
      if (wake_hit) wake_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfull_q <= 1'b0; ferr_q <= 1'b0; ovr_q <= 1'b0; mpb_q <= 1'b0;
      rdr_q   <= '0;
    end else begin
      if (rd_rx) rfull_q <= 1'b0;
      if (wr_stat && !wdata[S_FERR]) ferr_q <= 1'b0;
      if (wr_stat && !wdata[S_OVR])  ovr_q  <= 1'b0;
      if (accepted) begin
        mpb_q <= frame.mpb;
        if (!frame.stop_ok) ferr_q <= 1'b1;
        if (overrun_ev) begin
          ovr_q <= 1'b1;
        end else begin
          rfull_q <= 1'b1;
          rdr_q   <= frame.data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tde_q <= 1'b1; tend_q <= 1'b1; arm_q <= 1'b0; tdr_q <= '0;
    end else begin
      if (wr_tdr) tdr_q <= wdata;
      if (rd_stat && tde_q) arm_q <= 1'b1;
      else if (wr_stat)     arm_q <= 1'b0;
      if (tde_clear) begin
        tde_q  <= 1'b0;
        tend_q <= 1'b0;
      end
      if (tx_load)  tde_q  <= 1'b1;
      if (tend_set) tend_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {2'b00, txmpb_q, teie_q, eie_q, rie_q, wake_q, mp_q};
      A_STAT:  rdata = {2'b00, tend_q, tde_q, mpb_q, ovr_q, ferr_q, rfull_q};
      A_RXD:   rdata = rdr_q;
      default: rdata = tdr_q;
    endcase
  end

  assign mp_fmt     = mp_q;
  assign tx_mpb     = txmpb_q;
  assign tx_pending = ~tde_q;
  assign tx_data    = tdr_q;
  assign irq_rx     = rfull_q & rie_q;
  assign irq_rxerr  = (ferr_q | ovr_q) & eie_q;
  assign irq_txend  = tend_q & teie_q;

  // R1
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && !overrun_ev |=> rfull_q && rdr_q == $past(frame.data));
  // R4
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> ovr_q && $stable(rdr_q));
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !accepted |=> !rfull_q);
  // R6
  suppress_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suppressed && !rfull_q && !ferr_q && !ovr_q |=> !rfull_q && !ferr_q && !ovr_q && $stable(rdr_q));
  // R7
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !wake_q && mpb_q);
  // R10
  tend_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tend_q) |-> $past(arm_q) && !tde_q || $past(tx_load));
  // R11
  tend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend_q) |-> $past(tx_done));
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdrop_uart_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int TICK_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       txd,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_rx,
  output logic       irq_rxerr,
  output logic       irq_txend
);
  logic              tick;
  logic              rx_frame_done, rx_false_start;
  rx_frame_t         rx_frame;
  logic              mp_fmt, tx_mpb, tx_pending, tx_load, tx_done;
  logic [DATA_W-1:0] tx_data;

  mdrop_uart_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  mdrop_uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mp_fmt(mp_fmt),
    .frame_done(rx_frame_done), .frame(rx_frame), .false_start(rx_false_start)
  );

  mdrop_uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pending(tx_pending), .data(tx_data),
    .mpb(tx_mpb), .mp_fmt(mp_fmt), .load(tx_load), .done(tx_done), .txd(txd)
  );

  mdrop_uart_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_done(rx_frame_done), .frame(rx_frame),
    .tx_load(tx_load), .tx_done(tx_done), .mp_fmt(mp_fmt), .tx_mpb(tx_mpb),
    .tx_pending(tx_pending), .tx_data(tx_data),
    .irq_rx(irq_rx), .irq_rxerr(irq_rxerr), .irq_txend(irq_txend)
  );

  // R2
  no_frame_on_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_false_start |-> !rx_frame_done);
endmodule

// File: tb/mdrop_uart_tb_top.sv
`timescale 1ns/1ps
module mdrop_uart_tb_top;
  localparam int BITT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_rx, irq_rxerr, irq_txend;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  mdrop_uart dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_rx(irq_rx), .irq_rxerr(irq_rxerr), .irq_txend(irq_txend)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // glitch: frame bit index (1..8 data) whose centre tick is inverted; -1 none
  task automatic send(input logic [7:0] d, input logic mp, input logic mpb,
                      input logic stop_v, input int glitch);
    logic [10:0] bits;
    int nb;
    bits = mp ? {stop_v, mpb, d, 1'b0} : {1'b1, stop_v, d, 1'b0};
    nb = mp ? 11 : 10;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rxd = bits[i];
      if (i == glitch) begin
        repeat (9) @(negedge clk);
        rxd = ~bits[i];
        @(negedge clk);
        rxd = bits[i];
        repeat (5) @(negedge clk);
      end else begin
        repeat (BITT - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic grab_tx(input logic [10:0] exp, input int nb);
    int guard;
    guard = 0;
    while (txd !== 1'b0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      check("R11 txd bit", {7'd0, txd}, {7'd0, exp[i]});
      repeat (BITT) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R10: empty and end both 1)
    rd_reg(2'd0, v); check("R10 reset ctrl", v, 8'h00);
    rd_reg(2'd1, v); check("R10 reset stat", v, 8'h30);
    check("R5 reset irqs", {5'd0, irq_rx, irq_rxerr, irq_txend}, 8'h00);

    // R1 sweep: all bytes, multiprocessor format, mpb = lsb
    wr_reg(2'd0, 8'h05);
    for (int k = 0; k < 256; k++) begin
      send(8'(k), 1'b1, k[0], 1'b1, -1);
      check("R5 irq_rx set", {7'd0, irq_rx}, 8'h01);
      rd_reg(2'd1, v);
      check("R1 rfull/mpb", v & 8'h0F, {4'd0, k[0], 3'b001});
      rd_reg(2'd2, v); check("R1 data", v, 8'(k));
      rd_reg(2'd1, v); check("R5 rfull cleared", v & 8'h01, 8'h00);
    end

    // R1 plain format bytes
    wr_reg(2'd0, 8'h04);
    for (int k = 0; k < 16; k++) begin
      send(8'(k * 17 + 3), 1'b0, 1'b0, 1'b1, -1);
      rd_reg(2'd2, v); check("R1 plain data", v, 8'(k * 17 + 3));
    end

    // R2 glitch and false start
    send(8'h00, 1'b0, 1'b0, 1'b1, 4);
    rd_reg(2'd2, v); check("R2 glitch low", v, 8'h00);
    send(8'hFF, 1'b0, 1'b0, 1'b1, 6);
    rd_reg(2'd2, v); check("R2 glitch high", v, 8'hFF);
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    rd_reg(2'd1, v); check("R2 false start", v & 8'h07, 8'h00);

    // R3 framing error
    wr_reg(2'd0, 8'h0C);
    send(8'h3C, 1'b0, 1'b0, 1'b0, -1);
    rd_reg(2'd1, v); check("R3 ferr set", v & 8'h07, 8'h03);
    check("R5 irq_rxerr", {7'd0, irq_rxerr}, 8'h01);
    rd_reg(2'd2, v); check("R3 data kept", v, 8'h3C);
    wr_reg(2'd1, 8'h12);
    rd_reg(2'd1, v); check("R3 write1 keeps", v & 8'h02, 8'h02);
    wr_reg(2'd1, 8'h10);
    rd_reg(2'd1, v); check("R3 ferr clear", v & 8'h02, 8'h00);
    check("R5 irq_rxerr low", {7'd0, irq_rxerr}, 8'h00);

    // R4 overrun
    send(8'h11, 1'b0, 1'b0, 1'b1, -1);
    send(8'h22, 1'b0, 1'b0, 1'b1, -1);
    rd_reg(2'd1, v); check("R4 ovr set", v & 8'h07, 8'h05);
    check("R5 irq_rxerr ovr", {7'd0, irq_rxerr}, 8'h01);
    rd_reg(2'd2, v); check("R4 old data", v, 8'h11);
    wr_reg(2'd1, 8'h10);
    rd_reg(2'd1, v); check("R4 ovr clear", v & 8'h07, 8'h00);

    // R6 suppression while waiting for address
    wr_reg(2'd0, 8'h0F);
    send(8'h99, 1'b1, 1'b0, 1'b0, -1);
    rd_reg(2'd1, v); check("R6 no flags", v & 8'h0F, 8'h00);
    check("R6 no irqs", {6'd0, irq_rx, irq_rxerr}, 8'h00);
    rd_reg(2'd0, v); check("R6 wake kept", v, 8'h0F);
    rd_reg(2'd2, v); check("R6 data untouched", v, 8'h11);

    // R7 address frame wakes
    send(8'h5A, 1'b1, 1'b1, 1'b1, -1);
    rd_reg(2'd0, v); check("R7 wake cleared", v, 8'h0D);
    check("R7 irq_rx", {7'd0, irq_rx}, 8'h01);
    rd_reg(2'd1, v); check("R7 mpb rfull", v & 8'h0F, 8'h09);
    rd_reg(2'd2, v); check("R7 addr data", v, 8'h5A);
    send(8'h66, 1'b1, 1'b0, 1'b1, -1);
    rd_reg(2'd2, v); check("R7 data after wake", v, 8'h66);

    // R8 wake ignored in plain format
    wr_reg(2'd0, 8'h06);
    send(8'h77, 1'b0, 1'b0, 1'b1, -1);
    rd_reg(2'd2, v); check("R8 received", v, 8'h77);
    rd_reg(2'd0, v); check("R8 wake kept", v, 8'h06);

    // R9 transmit-end interrupt gating
    wr_reg(2'd0, 8'h31);
    check("R9 irq_txend on", {7'd0, irq_txend}, 8'h01);
    wr_reg(2'd0, 8'h21);
    check("R9 irq_txend withdrawn", {7'd0, irq_txend}, 8'h00);
    wr_reg(2'd0, 8'h31);

    // R10 write without prior read does nothing
    wr_reg(2'd3, 8'hA7);
    wr_reg(2'd1, 8'h10);
    wr_reg(2'd1, 8'h00);
    @(negedge clk);
    check("R10 no-read write", {7'd0, irq_txend}, 8'h01);
    rd_reg(2'd1, v); check("R10 flags kept", v & 8'h30, 8'h30);

    // R10/R11 handshake then transmit several frames
    for (int k = 0; k < 8; k++) begin
      logic mp;
      logic [7:0] d;
      mp = k[0];
      d = 8'(k * 37 + 5);
      wr_reg(2'd0, mp ? 8'h31 : 8'h30);
      wr_reg(2'd3, d);
      rd_reg(2'd1, v);
      wr_reg(2'd1, 8'h00);
      rd_reg(2'd1, v); check("R10 tend cleared", v & 8'h20, 8'h00);
      check("R9 irq_txend low", {7'd0, irq_txend}, 8'h00);
      grab_tx(mp ? {2'b11, d, 1'b0} : {3'b111, d, 1'b0}, mp ? 11 : 10);
      rd_reg(2'd1, v); check("R11 tend set", v & 8'h30, 8'h30);
      check("R9 irq_txend high", {7'd0, irq_txend}, 8'h01);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule